// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock timing for an SPI master from the core clock. A prescale field chooses the division ratio, and one of two decode schemes interprets that field. The block drives two registered outputs. `half_tick` is a one-cycle strobe at every serial clock edge. `sck_ref` is a level that toggles at each of those strobes and gives the serial clock shape.

In extended decode, the field holds a 4-bit mantissa and a 3-bit exponent, and the divisor is the mantissa shifted left by the exponent. The exponent is split: its low bit sits just above the mantissa, and its two upper bits sit one position higher still, which leaves a gap bit between them. In legacy decode, only the low nibble is used, and it holds half of an even divisor. Both schemes clamp the result so that the serial clock never runs faster than a quarter of the core clock.

A period starts with the low phase and ends with the high phase. A new field value is picked up at the end of a high phase, or at any time while the run enable is low. This lets software retune the rate on a running clock without producing a runt phase.

Top module: `sck_prescaler`

## Requirements
- R1: With `ext_mode`=1, the divisor is M×2^E. M is `presc_field[3:0]`. E is formed as {`presc_field[7]`, `presc_field[6]`, `presc_field[4]`}, with `presc_field[4]` as the least significant bit of E. `presc_field[5]` has no effect on the output.
- R2: With `ext_mode`=1, any divisor below 4 is replaced by 4. This includes every case with M=0.
- R3: With `ext_mode`=0, the divisor is 2×`presc_field[3:0]` for nibble values 2 to 15. `presc_field[7:4]` has no effect on the output.
- R4: With `ext_mode`=0, a nibble value of 0 or 1 gives a divisor of 4.
- R5: A period of divisor D begins with `sck_ref`=0 for floor(D/2) cycles, followed by `sck_ref`=1 for ceil(D/2) cycles.
- R6: `half_tick` is high for exactly one cycle, and only at the clock edge where `sck_ref` toggles while running.
- R7: After enabling, the first `half_tick` and the first rise of `sck_ref` come at the floor(D/2)-th rising edge at which `run_en` is sampled high.
- R8: A field or mode change made while running applies only from the next period, that is, after the edge that ends the current high phase.
- R9: At each edge where `run_en` is sampled low, the block clears its counter and drives both outputs to 0. It also loads the current field, which then governs the next run.
- R10: A synchronous active-low reset drives `half_tick` and `sck_ref` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 1 selects mantissa/exponent decode, 0 selects legacy even decode |
| presc_field | input | 8 | Prescale field from the configuration register |
| run_en | input | 1 | Run enable; low holds the generator idle |
| half_tick | output | 1 | One-cycle strobe at each serial clock edge |
| sck_ref | output | 1 | Serial clock reference level |

## Verification
Both outputs are registered. Each one reflects the inputs and state sampled at a rising edge and can be observed from just after that same edge. A changed field therefore shows up in the tick pattern no earlier than the edge that closes the current high phase, and an enable drop shows up after one edge. The bench advances its own period-position model at every rising edge, using only the inputs it drove at the preceding falling edge. It compares both outputs at the following falling edge, so each expected value is read exactly one register stage after the stimulus that causes it.

// File: rtl/sck_presc_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial clock prescaler.
package sck_presc_pkg;
    // Decode scheme applied to the prescale field.
    typedef enum logic {
        DEC_LEGACY = 1'b0,
        DEC_EXTEND = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/sckp_decode.sv
`timescale 1ns/1ps
// sckp_decode: turns the prescale field into low/high phase lengths.
// Assumes: field width = SPR_W + SPPR_W + 1 (one gap bit inside the exponent
// split); LEG_W <= SPR_W + SPPR_W; MIN_DIV >= 2 so both phases are >= 1.
module sckp_decode
    import sck_presc_pkg::*;
#(
    parameter int SPR_W   = 4,
    parameter int SPPR_W  = 3,
    parameter int LEG_W   = 4,
    parameter int MIN_DIV = 4,
    parameter int FIELD_W = SPR_W + SPPR_W + 1,
    parameter int DIV_W   = SPR_W + (1 << SPPR_W) - 1
) (
    input  dec_mode_e          mode,
    input  logic [FIELD_W-1:0] field,
    output logic [DIV_W-1:0]   lo_len,
    output logic [DIV_W-1:0]   hi_len
);
    localparam int EXP_LO_POS = SPR_W;
    localparam int GAP_POS    = SPR_W + 1;
    localparam int EXP_HI_POS = SPR_W + 2;

    logic [SPR_W-1:0]  mant;
    logic [SPPR_W-1:0] expo;
    logic [DIV_W-1:0]  ext_raw;
    logic [DIV_W-1:0]  leg_raw;
    logic [DIV_W-1:0]  div_sel;
    logic [DIV_W:0]    div_p1;
    logic              unused_gap;

    assign unused_gap = field[GAP_POS];

    // Gather mantissa and the split exponent from their field positions.
    always_comb begin
        mant = field[SPR_W-1:0];
        expo = {field[EXP_HI_POS +: SPPR_W-1], field[EXP_LO_POS]};
    end

    // Form both candidate divisors and clamp the selected one to the minimum.
    always_comb begin
        ext_raw = DIV_W'(mant) << expo;
        leg_raw = DIV_W'({field[LEG_W-1:0], 1'b0});
        div_sel = (mode == DEC_EXTEND) ? ext_raw : leg_raw;
        if (div_sel < DIV_W'(MIN_DIV))
            div_sel = DIV_W'(MIN_DIV);
    end

    // Split the divisor: low phase gets the floor, high phase the ceiling.
    always_comb begin
        div_p1 = {1'b0, div_sel} + (DIV_W+1)'(1);
        lo_len = div_sel >> 1;
        hi_len = div_p1[DIV_W:1];
    end
endmodule

// File: rtl/sckp_phase_gen.sv
`timescale 1ns/1ps
// sckp_phase_gen: counts core clocks through the low and high phases and
// emits a strobe at each phase end.
// Assumes: lo_len and hi_len are both >= 1 (guaranteed by the decoder clamp);
// the lengths are sampled only at a period end or while idle.
module sckp_phase_gen #(
    parameter int DIV_W   = 11,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] lo_len,
    input  logic [DIV_W-1:0] hi_len,
    output logic             tick,
    output logic             level
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lat_lo;
    logic [DIV_W-1:0] lat_hi;
    logic [DIV_W-1:0] cur_len;
    logic             ph;
    logic             tick_q;
    logic             phase_end;

    assign tick  = tick_q;
    assign level = ph;

    // Select the length of the phase in progress and detect its last cycle.
    always_comb begin
        cur_len   = ph ? lat_hi : lat_lo;
        phase_end = (cnt == cur_len - DIV_W'(1));
    end

    // Phase counter, phase flag, strobe and period-boundary length capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cnt    <= '0;
            ph     <= 1'b0;
            tick_q <= 1'b0;
            lat_lo <= lo_len;
            lat_hi <= hi_len;
        end else if (phase_end) begin
            cnt    <= '0;
            ph     <= ~ph;
            tick_q <= 1'b1;
            if (ph) begin
                lat_lo <= lo_len;
                lat_hi <= hi_len;
            end
        end else begin
            cnt    <= cnt + DIV_W'(1);
            tick_q <= 1'b0;
        end
    end

    // R6
    tick_on_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && $past(rst_n)) |-> (tick_q == (ph != $past(ph))));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_en)) |-> (!tick_q && !ph && cnt == '0));

    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && $past(rst_n) && !(tick_q && !ph))
            |-> ($stable(lat_lo) && $stable(lat_hi)));

    // R5
    phase_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, hi_len} + {1'b0, lo_len}) >= (DIV_W+1)'(MIN_DIV))
            && (hi_len >= lo_len) && ((hi_len - lo_len) <= DIV_W'(1)));
endmodule

// File: rtl/sck_prescaler.sv
`timescale 1ns/1ps
// sck_prescaler: serial clock prescaler for an SPI master. Decodes the
// prescale field in one of two schemes and times the serial clock phases.
// Assumes: synchronous active-low reset; field is static or changed by
// software, with changes taking effect at the next period boundary.
module sck_prescaler
    import sck_presc_pkg::*;
#(
    parameter int SPR_W   = 4,
    parameter int SPPR_W  = 3,
    parameter int LEG_W   = 4,
    parameter int MIN_DIV = 4,
    parameter int FIELD_W = SPR_W + SPPR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [FIELD_W-1:0] presc_field,
    input  logic               run_en,
    output logic               half_tick,
    output logic               sck_ref
);
    localparam int DIV_W = SPR_W + (1 << SPPR_W) - 1;

    dec_mode_e        mode;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] hi_len;

    // Map the mode pin onto the decode enum.
    always_comb mode = ext_mode ? DEC_EXTEND : DEC_LEGACY;

    sckp_decode #(
        .SPR_W   (SPR_W),
        .SPPR_W  (SPPR_W),
        .LEG_W   (LEG_W),
        .MIN_DIV (MIN_DIV),
        .FIELD_W (FIELD_W),
        .DIV_W   (DIV_W)
    ) u_decode (
        .mode   (mode),
        .field  (presc_field),
        .lo_len (lo_len),
        .hi_len (hi_len)
    );

    sckp_phase_gen #(
        .DIV_W   (DIV_W),
        .MIN_DIV (MIN_DIV)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .lo_len (lo_len),
        .hi_len (hi_len),
        .tick   (half_tick),
        .level  (sck_ref)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (!half_tick && !sck_ref));
endmodule

// File: tb/sck_prescaler_tb.sv
`timescale 1ns/1ps
module sck_prescaler_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] presc_field = 8'h12;
    logic       run_en = 1'b0;
    logic       half_tick;
    logic       sck_ref;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    int mdiv = 4;
    bit exp_tick = 0;
    bit exp_sck = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sck_prescaler u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .presc_field(presc_field), .run_en(run_en),
        .half_tick(half_tick), .sck_ref(sck_ref)
    );

    // Divisor from the requirement text (R1..R4).
    function automatic int ref_div(bit m, logic [7:0] f);
        int d;
        if (m) begin
            d = int'(f[3:0]) << (int'(f[4]) + 2 * int'(f[6]) + 4 * int'(f[7]));
            if (d < 4) d = 4;
        end else begin
            d = (f[3:0] < 2) ? 4 : 2 * int'(f[3:0]);
        end
        return d;
    endfunction

    // One clock: advance the period model at the edge, compare after it.
    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n || !run_en) begin
            pos = 0; mdiv = ref_div(ext_mode, presc_field);
            exp_tick = 0; exp_sck = 0;
        end else begin
            pos = pos + 1;
            exp_tick = (pos == mdiv / 2) || (pos == mdiv);
            exp_sck  = (pos >= mdiv / 2) && (pos < mdiv);
            if (pos == mdiv) begin
                pos = 0; mdiv = ref_div(ext_mode, presc_field);
            end
        end
        @(negedge clk);
        checks++;
        if (half_tick !== exp_tick || sck_ref !== exp_sck) begin
            errors++;
            $display("FAIL %s: tick=%0b sck=%0b expected tick=%0b sck=%0b",
                     tag, half_tick, sck_ref, exp_tick, exp_sck);
        end
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Load a setting while idle, then enable.
    task automatic start(input bit m, input logic [7:0] f, input string tag);
        run_en = 0; ext_mode = m; presc_field = f;
        run(tag, 2);
        run_en = 1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1234);
        run("R10", 3);                         // reset state
        rst_n = 1;
        run("R10", 2);
        start(1, 8'h55, "R1"); run("R1", 90);  // 5 x 2^3 = 40
        start(1, 8'h75, "R1"); run("R1", 90);  // gap bit set, still 40
        start(1, 8'hC9, "R1"); run("R1", 1200);// 9 x 2^6 = 576
        start(1, 8'h03, "R2"); run("R2", 20);  // 3 -> 4
        start(1, 8'hB0, "R2"); run("R2", 20);  // mantissa 0 -> 4
        start(1, 8'h07, "R5"); run("R5", 30);  // odd: low 3, high 4
        start(0, 8'h1F, "R3"); run("R3", 70);  // 30
        start(0, 8'hE7, "R3"); run("R3", 40);  // upper bits ignored: 14
        start(0, 8'h10, "R4"); run("R4", 20);
        start(0, 8'h11, "R4"); run("R4", 20);
        start(0, 8'h16, "R7"); run("R7", 8);   // first tick at 6th edge
        start(0, 8'h1F, "R8"); run("R8", 20);  // in high phase
        presc_field = 8'h13; run("R8", 40);
        start(0, 8'h1F, "R8"); run("R8", 5);   // in low phase
        ext_mode = 1; presc_field = 8'h05; run("R8", 50);
        start(1, 8'h55, "R9"); run("R9", 30);
        run_en = 0; run("R9", 4);
        presc_field = 8'h07; run("R9", 3);
        run_en = 1; run("R9", 25);
        start(0, 8'h15, "R10"); run("R10", 7);
        rst_n = 0; run("R10", 3);
        rst_n = 1; run("R10", 25);
        for (int i = 0; i < 30; i++) begin
            bit m;
            logic [7:0] f;
            int n;
            m = 1'($urandom % 2);
            f = 8'($urandom);
            n = 2 * ref_div(m, f) + 6;
            if (n > 900) n = 900;
            start(m, f, m ? "R1" : "R3");
            run(m ? "R1" : "R3", n);
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule